// File: doc/BRIEF.md
# System Reset Control Register

This block is a single byte-wide register on a simple host I/O bus, placed at the legacy reset-control port address 0xCF9. Software writes a byte to it. When bit 2 of that byte is set, the block raises a one-cycle system reset request. The block keeps the byte and returns it on later reads.

Bit 1 of the stored byte selects the reset type and appears on its own output. The value 0 means soft and 1 means hard. Both types give exactly the same request pulse, and the system's reset sequencer may use the type output or ignore it.

The block decodes only its own address. It accepts only single-byte accesses. An access of any other size at its address earns an error pulse and changes nothing.

Top module: `rst_ctl_reg`

## Requirements
- R1: After the synchronous active-high reset, the stored byte is 0x00, `rst_req`, `rst_type`, `rd_valid` and `err` are 0, and a following read returns 0x00.
- R2: A write with `bus_size` = 1 at address 0xCF9 stores `bus_wdata[7:0]`. Bits 31:8 of the write data are discarded. A later one-byte read at 0xCF9 sets `rd_valid` one cycle after the strobe, and `bus_rdata` then carries the stored byte zero-extended to 32 bits.
- R3: `rst_req` is high for exactly the one cycle after each accepted write whose bit 2 is 1. It stays low after accepted writes whose bit 2 is 0.
- R4: `rst_type` equals bit 1 of the stored byte, with 0 meaning soft and 1 meaning hard. The request pulse is identical for both types.
- R5: An access at 0xCF9 with `bus_size` other than 1 raises `err` for one cycle after the strobe. It stores nothing, requests no reset and gives no read data.
- R6: Accesses at any other address are ignored. They produce no `err`, no `rd_valid` and no `rst_req`, and they leave the stored byte unchanged.
- R7: When a read and a write to 0xCF9 fall in the same cycle, the read returns the byte held before that write, and the write still takes effect, including any reset request.
- R8: `bus_rdata` is 0 in every cycle in which `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | I/O port address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data, low byte used |
| bus_rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read response, one cycle after the read strobe |
| err | output | 1 | Bad access size at this address, one cycle after the strobe |
| rst_req | output | 1 | One-cycle system reset request |
| rst_type | output | 1 | Selected reset type: 0 soft, 1 hard |

## Verification
A read can land in the same cycle as a write that sets the reset bit. In that cycle the read response and the reset request must both come out on the following cycle. The bench provokes this by raising both strobes together with a byte that has bit 2 set. It then checks three things: the read data shows the byte held before the write, `rst_req` pulses in that same response cycle, and a separate follow-up read shows the new byte.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

    localparam int REG_W = 8;

    // Decoded view of one bus cycle
    typedef struct packed {
        logic wr_ok;   // accepted one-byte write at our address
        logic rd_ok;   // accepted one-byte read at our address
        logic bad;     // access at our address with a wrong size
    } rcr_acc_t;

    function automatic logic bit_at(input logic [REG_W-1:0] v, input int idx);
        return v[idx];
    endfunction

endpackage

// File: rtl/rcr_decode.sv
module rcr_decode
    import rcr_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                SIZE_W    = 3,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9,
    parameter int                NBYTES    = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [SIZE_W-1:0] size,
    output rcr_acc_t          acc
);
    localparam logic [SIZE_W-1:0] SIZE_OK = SIZE_W'(NBYTES);

    logic hit;
    logic size_ok;

    always_comb begin
        hit       = (addr == PORT_ADDR);
        size_ok   = (size == SIZE_OK);
        acc.wr_ok = hit && wr && size_ok;
        acc.rd_ok = hit && rd && size_ok;
        acc.bad   = hit && (wr || rd) && !size_ok;
    end
endmodule

// File: rtl/rcr_store.sv
module rcr_store
    import rcr_pkg::*;
#(
    parameter int RST_BIT  = 2,
    parameter int TYPE_BIT = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ok,
    input  logic [REG_W-1:0] wbyte,
    output logic [REG_W-1:0] value,
    output logic             rst_req,
    output logic             rst_type
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value   <= '0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= wr_ok && bit_at(wbyte, RST_BIT);
            if (wr_ok) begin
                value <= wbyte;
            end
        end
    end

    assign rst_type = bit_at(value, TYPE_BIT);
endmodule

// File: rtl/rcr_resp.sv
module rcr_resp
    import rcr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_ok,
    input  logic              bad,
    input  logic [REG_W-1:0]  value,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid,
    output logic              err
);
    logic [DATA_W-1:0] wide;

    generate
        if (DATA_W > REG_W) begin : g_ext
            assign wide = {{(DATA_W-REG_W){1'b0}}, value};
        end else begin : g_trunc
            assign wide = value[DATA_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata    <= '0;
            rd_valid <= 1'b0;
            err      <= 1'b0;
        end else begin
            rd_valid <= rd_ok;
            err      <= bad;
            rdata    <= rd_ok ? wide : '0;
        end
    end
endmodule

// File: rtl/rst_ctl_reg.sv
module rst_ctl_reg
    import rcr_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 32,
    parameter int                SIZE_W    = 3,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9,
    parameter int                RST_BIT   = 2,
    parameter int                TYPE_BIT  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [SIZE_W-1:0] bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rd_valid,
    output logic              err,
    output logic              rst_req,
    output logic              rst_type
);
    localparam int NBYTES = REG_W / 8;

    rcr_acc_t         acc;
    logic [REG_W-1:0] value;

    rcr_decode #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .PORT_ADDR(PORT_ADDR), .NBYTES(NBYTES)
    ) u_decode (
        .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .size(bus_size), .acc(acc)
    );

    rcr_store #(
        .RST_BIT(RST_BIT), .TYPE_BIT(TYPE_BIT)
    ) u_store (
        .clk(clk), .rst(rst), .wr_ok(acc.wr_ok), .wbyte(bus_wdata[REG_W-1:0]),
        .value(value), .rst_req(rst_req), .rst_type(rst_type)
    );

    rcr_resp #(
        .DATA_W(DATA_W)
    ) u_resp (
        .clk(clk), .rst(rst), .rd_ok(acc.rd_ok), .bad(acc.bad), .value(value),
        .rdata(bus_rdata), .rd_valid(rd_valid), .err(err)
    );
endmodule

// File: rtl/rst_ctl_reg_chk.sv
module rst_ctl_reg_chk #(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 32,
    parameter int                SIZE_W    = 3,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9,
    parameter int                RST_BIT   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [SIZE_W-1:0] bus_size,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              rd_valid,
    input logic              err,
    input logic              rst_req,
    input logic              rst_type
);
    // R3
    req_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(bus_wr && bus_addr == PORT_ADDR && bus_size == 1 && bus_wdata[RST_BIT]));

    // R5
    err_no_side_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> ($stable(rst_type) && !rst_req && !rd_valid));

    // R2
    rd_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(bus_rd && bus_addr == PORT_ADDR && bus_size == 1));

    // R6
    own_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (err || rd_valid || rst_req) |-> $past(bus_addr == PORT_ADDR));

    // R8
    rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> bus_rdata == '0);
endmodule

bind rst_ctl_reg rst_ctl_reg_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W), .PORT_ADDR(PORT_ADDR), .RST_BIT(RST_BIT)
) u_chk (.*);

// File: tb/tb_rst_ctl_reg.sv
`timescale 1ns/1ps
module tb_rst_ctl_reg;
    localparam logic [15:0] PORT = 16'hCF9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rd_valid, err, rst_req, rst_type;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rst_ctl_reg dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rd_valid(rd_valid), .err(err), .rst_req(rst_req), .rst_type(rst_type)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One bus cycle; returns just after the edge that registers the response
    task automatic access(input logic [15:0] a, input logic w, input logic r,
                          input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_rd = r; bus_size = s; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic read_expect(input string req, input logic [7:0] exp);
        access(PORT, 1'b0, 1'b1, 3'd1, 32'h0);
        check({req, " rd_valid"}, rd_valid, 1);
        check({req, " rdata"}, bus_rdata, {24'h0, exp});
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check("R1 rst_req", rst_req, 0);
        check("R1 rst_type", rst_type, 0);
        check("R1 rd_valid", rd_valid, 0);
        check("R1 err", err, 0);
        read_expect("R1", 8'h00);
    endtask

    task automatic t_store();
        access(PORT, 1'b1, 1'b0, 3'd1, 32'hA3);      // bit2=0, bit1=1
        check("R3 no pulse", rst_req, 0);
        check("R4 type hard", rst_type, 1);
        check("R8 rdata idle", bus_rdata, 0);
        read_expect("R2", 8'hA3);
        access(PORT, 1'b1, 1'b0, 3'd1, 32'hFFFF_FF01); // upper bits dropped
        read_expect("R2 upper", 8'h01);
    endtask

    task automatic t_pulse();
        access(PORT, 1'b1, 1'b0, 3'd1, 32'h5C);      // bit2=1, bit1=0
        check("R3 pulse", rst_req, 1);
        check("R4 type soft", rst_type, 0);
        @(posedge clk); #1;
        check("R3 one cycle", rst_req, 0);
        read_expect("R2", 8'h5C);
        access(PORT, 1'b1, 1'b0, 3'd1, 32'h06);      // hard
        check("R4 hard pulse", rst_req, 1);
        check("R4 hard type", rst_type, 1);
        @(posedge clk); #1;
        check("R4 hard one cycle", rst_req, 0);
    endtask

    task automatic t_bad_size();
        access(PORT, 1'b1, 1'b0, 3'd2, 32'h04);
        check("R5 err wr", err, 1);
        check("R5 no pulse", rst_req, 0);
        access(PORT, 1'b0, 1'b1, 3'd4, 32'h0);
        check("R5 err rd", err, 1);
        check("R5 no rd_valid", rd_valid, 0);
        check("R5 rdata zero", bus_rdata, 0);
        read_expect("R5 unchanged", 8'h06);
        check("R5 err clear", err, 0);
    endtask

    task automatic t_other();
        access(16'hCF8, 1'b1, 1'b0, 3'd1, 32'h04);
        check("R6 no pulse", rst_req, 0);
        check("R6 no err", err, 0);
        access(16'hCFA, 1'b0, 1'b1, 3'd1, 32'h0);
        check("R6 no rd_valid", rd_valid, 0);
        check("R6 no err rd", err, 0);
        read_expect("R6 unchanged", 8'h06);
    endtask

    task automatic t_same_cycle();
        access(PORT, 1'b1, 1'b1, 3'd1, 32'h04);
        check("R7 rd_valid", rd_valid, 1);
        check("R7 old data", bus_rdata, 32'h06);
        check("R7 pulse", rst_req, 1);
        check("R7 type", rst_type, 0);
        read_expect("R7 new data", 8'h04);
    endtask

    initial begin
        t_reset();
        t_store();
        t_pulse();
        t_bad_size();
        t_other();
        t_same_cycle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule